// File: doc/BRIEF.md
# Serial Management Frame Slave

This block is the management-port slave of a PHY. It samples the bidirectional management data line on every rising edge of the management clock. It waits for an idle run of ones, then decodes one frame at a time: a start pair, an operation code, a device address, a register address, a two-bit turnaround and a data word. The device address is compared with a strapped address, and a frame that names another device leaves the block silent.

A matching write frame ends in a single-cycle write strobe carrying the register address and the data word. A matching read frame raises a single-cycle read request toward the register file, then takes the line for the second turnaround bit and shifts the returned word out, most significant bit first. Each driven bit changes just after the clock edge on which the master samples, so it is stable at the master's next rising-edge sample.

Both register-file transfers are strobes without back-pressure, because the serial frame cannot be stalled. The write strobe must be accepted in the cycle it is high. The read data must be valid at the clock edge that ends the request cycle. A malformed start or operation code drops the frame, with no side effects.

Top module: `mdio_slave`

## Requirements
- R1: After reset, mdio_oe, wr_valid and rd_req are all 0.
- R2: In a write frame (operation bits 01) whose device address equals phy_strap, wr_valid is high for exactly one cycle, starting at the edge that samples the last data bit. In that cycle wr_addr and wr_data hold the frame's register address and data word, the data taken MSB first. mdio_oe stays 0 for the whole write frame.
- R3: In a read frame (operation bits 10) whose device address matches, rd_req is high for exactly one cycle, starting at the edge that samples the last register address bit, and rd_addr holds that address. rd_data is captured at the edge that ends that cycle.
- R4: In a matching read, mdio_oe stays 0 during the first turnaround bit. During the second turnaround bit mdio_oe is 1 and mdio_o is 0.
- R5: In a matching read, the 16 data bits are driven MSB first. Each bit is set at the rising edge before the one on which the master samples it. mdio_oe drops at the edge that samples the last data bit.
- R6: When the device address differs from phy_strap, the frame causes no mdio_oe, no rd_req and no wr_valid.
- R7: A start bit of 0 is accepted only after at least 32 consecutive sampled ones. A run of 31 ones followed by a frame is ignored.
- R8: If the second start bit is 0 instead of 1, the frame is dropped with no strobe, request or drive.
- R9: Operation codes 00 and 11 drop the frame with no strobe, request or drive.
- R10: Each frame needs a fresh idle run of at least 32 ones. A frame sent directly after a completed frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling and driving happen on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mdio_i | input | 1 | Sampled value of the management data line |
| mdio_o | output | 1 | Value the slave drives onto the line |
| mdio_oe | output | 1 | Tristate enable for mdio_o |
| phy_strap | input | 5 | Strapped device address |
| wr_valid | output | 1 | One-cycle register write strobe |
| wr_addr | output | 5 | Register address of the write |
| wr_data | output | 16 | Write data word |
| rd_req | output | 1 | One-cycle register read request |
| rd_addr | output | 5 | Register address of the read |
| rd_data | input | 16 | Read data, valid at the edge that ends rd_req |

## Verification
The bench builds the block with its default parameters: 5-bit addresses, a 16-bit data word and a 32-one idle threshold. These values give the 32-bit frame, in which the turnaround falls on bits 14 and 15 and the last data bit on bit 31, so each bit-time event can be checked at a fixed bit index. They also bring the idle boundary within reach: 31 ones are rejected and 32 are accepted. The bench also checks that the idle counter restarts after every frame.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;
  typedef enum logic {ST_HUNT, ST_FRAME} mdio_st_e;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mdio_pre_det.sv
// Counts consecutive sampled ones, saturating at the idle threshold.
module mdio_pre_det #(
  parameter int PRE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  input  logic clr,
  output logic pre_ok
);
  localparam int CW = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PRE_LEN);

  logic [CW-1:0] cnt;

  assign pre_ok = (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (clr || !bit_i)   cnt <= '0;
    else if (!pre_ok)         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mdio_rx_shift.sv
// MSB-first serial-in shift register.
module mdio_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         bit_i,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= {q[W-2:0], bit_i};
  end
endmodule

// File: rtl/mdio_tx_drv.sv
// Turnaround drive and MSB-first read data serializer.
module mdio_tx_drv #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          shift,
  input  logic          stop,
  input  logic [DW-1:0] load_data,
  output logic          mdio_o,
  output logic          mdio_oe
);
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (stop) begin
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (start) begin
      // second turnaround bit: slave drives 0
      sh      <= load_data;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b1;
    end else if (shift) begin
      mdio_o  <= sh[DW-1];
      sh      <= {sh[DW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
  import mdio_slv_pkg::*;
#(
  parameter int AW      = 5,
  parameter int DW      = 16,
  parameter int PRE_LEN = 32
) (
  input  logic          mdc,
  input  logic          rst_n,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic [AW-1:0] phy_strap,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data
);
  // Bit positions within a frame; position 0 is the first start bit.
  localparam int HW     = 2 + 2 * AW;        // opcode + two addresses
  localparam int P_ST2  = 1;
  localparam int P_OP   = 3;
  localparam int P_HDR  = 1 + HW;            // last register address bit
  localparam int P_TA1  = P_HDR + 1;
  localparam int P_TA2  = P_HDR + 2;
  localparam int P_LAST = P_TA2 + DW;
  localparam int PW     = $clog2(P_LAST + 1);

  localparam logic [PW-1:0] POS_ST2  = PW'(P_ST2);
  localparam logic [PW-1:0] POS_OP   = PW'(P_OP);
  localparam logic [PW-1:0] POS_HDR0 = PW'(2);
  localparam logic [PW-1:0] POS_HDR  = PW'(P_HDR);
  localparam logic [PW-1:0] POS_TA1  = PW'(P_TA1);
  localparam logic [PW-1:0] POS_TA2  = PW'(P_TA2);
  localparam logic [PW-1:0] POS_LAST = PW'(P_LAST);

  mdio_st_e        state;
  logic [PW-1:0]   pos;
  logic            in_frame;
  logic            pre_ok;
  logic [HW-2:0]   hdr_q;
  logic [DW-2:0]   dat_q;
  logic [HW-1:0]   hdr_now;
  logic [1:0]      op_early;
  logic            bad_start, bad_op, abort;
  logic            hdr_end, match;
  logic            rd_go, wr_go;
  logic [AW-1:0]   reg_q;

  assign in_frame  = (state == ST_FRAME);
  assign hdr_now   = {hdr_q, mdio_i};
  assign op_early  = {hdr_q[0], mdio_i};
  assign bad_start = in_frame && (pos == POS_ST2) && !mdio_i;
  assign bad_op    = in_frame && (pos == POS_OP) &&
                     (op_early != OP_RD) && (op_early != OP_WR);
  assign abort     = bad_start || bad_op;
  assign hdr_end   = in_frame && (pos == POS_HDR);
  assign match     = (hdr_now[2*AW-1 -: AW] == phy_strap);

  mdio_pre_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk(mdc), .rst_n(rst_n), .bit_i(mdio_i), .clr(in_frame), .pre_ok(pre_ok)
  );

  mdio_rx_shift #(.W(HW-1)) u_hdr (
    .clk(mdc), .rst_n(rst_n),
    .en(in_frame && (pos >= POS_HDR0) && (pos < POS_HDR)),
    .bit_i(mdio_i), .q(hdr_q)
  );

  mdio_rx_shift #(.W(DW-1)) u_dat (
    .clk(mdc), .rst_n(rst_n),
    .en(in_frame && (pos > POS_TA2) && (pos < POS_LAST)),
    .bit_i(mdio_i), .q(dat_q)
  );

  mdio_tx_drv #(.DW(DW)) u_tx (
    .clk(mdc), .rst_n(rst_n),
    .start(in_frame && rd_go && (pos == POS_TA1)),
    .shift(in_frame && rd_go && (pos >= POS_TA2) && (pos < POS_LAST)),
    .stop(in_frame && (pos == POS_LAST)),
    .load_data(rd_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // Frame sequencer
  always_ff @(posedge mdc) begin
    if (!rst_n) begin
      state <= ST_HUNT;
      pos   <= '0;
    end else if (!in_frame) begin
      if (pre_ok && !mdio_i) begin
        state <= ST_FRAME;
        pos   <= PW'(1);
      end
    end else if (abort || (pos == POS_LAST)) begin
      state <= ST_HUNT;
      pos   <= '0;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  // Header decision and register-file strobes
  always_ff @(posedge mdc) begin
    if (!rst_n) begin
      rd_go    <= 1'b0;
      wr_go    <= 1'b0;
      reg_q    <= '0;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      rd_req   <= 1'b0;
      wr_valid <= 1'b0;
      if (!in_frame) begin
        rd_go <= 1'b0;
        wr_go <= 1'b0;
      end else if (hdr_end) begin
        reg_q <= hdr_now[AW-1:0];
        rd_go <= match && (hdr_now[HW-1 -: 2] == OP_RD);
        wr_go <= match && (hdr_now[HW-1 -: 2] == OP_WR);
        if (match && (hdr_now[HW-1 -: 2] == OP_RD)) begin
          rd_req  <= 1'b1;
          rd_addr <= hdr_now[AW-1:0];
        end
      end else if ((pos == POS_LAST) && wr_go) begin
        wr_valid <= 1'b1;
        wr_addr  <= reg_q;
        wr_data  <= {dat_q, mdio_i};
      end
    end
  end
endmodule

// File: rtl/mdio_slave_chk.sv
module mdio_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic mdio_o,
  input logic mdio_oe,
  input logic rd_req,
  input logic wr_valid
);
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R2
  AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !mdio_oe); // R2
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R3
  AST_TA1_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !mdio_oe); // R4
  AST_TA2_DRIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (mdio_oe && !mdio_o)); // R4
  AST_DRIVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> $past(rd_req)); // R6
endmodule

bind mdio_slave mdio_slave_chk u_chk (
  .clk(mdc), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .rd_req(rd_req), .wr_valid(wr_valid)
);

// File: tb/mdio_slave_tb.sv
module mdio_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdio_m = 1'b0;
  logic        mdio_line;
  logic        mdio_o, mdio_oe;
  logic [4:0]  phy_strap = 5'h0B;
  logic        wr_valid, rd_req;
  logic [4:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : mdio_m;

  // Bench register file model
  function automatic logic [15:0] rf_val(input logic [4:0] a);
    return {~a, 6'b101100, a};
  endfunction
  assign rd_data = rd_req ? rf_val(rd_addr) : 16'h0000;

  mdio_slave u_dut (
    .mdc(clk), .rst_n(rst_n), .mdio_i(mdio_line), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .phy_strap(phy_strap), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Snapshots at the falling edge before rising edge i
  logic       s_oe [0:33];
  logic       s_o  [0:33];
  logic       s_req[0:33];
  logic       s_wrv[0:33];
  logic [4:0] s_ra [0:33];
  logic [4:0]  cap_wa;
  logic [15:0] cap_wd;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_ones(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      mdio_m = 1'b1;
    end
  endtask

  task automatic frame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] dat, input bit rd);
    logic [31:0] v;
    v = {st, op, phy, rg, (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : dat)};
    for (int i = 0; i < 34; i++) begin
      @(negedge clk);
      s_oe[i] = mdio_oe; s_o[i] = mdio_o; s_req[i] = rd_req;
      s_wrv[i] = wr_valid; s_ra[i] = rd_addr;
      if (i == 32) begin cap_wa = wr_addr; cap_wd = wr_data; end
      mdio_m = (i < 32) ? v[31-i] : 1'b0;
    end
  endtask

  task automatic expect_quiet(input string req);
    int a_oe, a_rq, a_wr;
    a_oe = 0; a_rq = 0; a_wr = 0;
    for (int i = 0; i < 34; i++) begin
      a_oe += int'(s_oe[i]); a_rq += int'(s_req[i]); a_wr += int'(s_wrv[i]);
    end
    chk({req, " no drive"}, a_oe, 0);
    chk({req, " no read request"}, a_rq, 0);
    chk({req, " no write strobe"}, a_wr, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 oe", mdio_oe, 0);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 rd_req", rd_req, 0);
  endtask

  task automatic t_write(input logic [4:0] rg, input logic [15:0] dat);
    int a_oe, a_wr;
    idle_ones(32);
    frame(2'b01, 2'b01, phy_strap, rg, dat, 1'b0);
    a_oe = 0; a_wr = 0;
    for (int i = 0; i < 32; i++) begin
      a_oe += int'(s_oe[i]); a_wr += int'(s_wrv[i]);
    end
    chk("R2 strobe at end", s_wrv[32], 1);
    chk("R2 strobe one cycle", s_wrv[33], 0);
    chk("R2 no early strobe", a_wr, 0);
    chk("R2 address", cap_wa, rg);
    chk("R2 data", cap_wd, dat);
    chk("R2 never drives", a_oe + int'(s_oe[32]), 0);
  endtask

  task automatic t_read(input logic [4:0] rg);
    logic [15:0] got;
    int oe_ok;
    idle_ones(32);
    frame(2'b01, 2'b10, phy_strap, rg, 16'h0, 1'b1);
    chk("R3 no early request", s_req[13], 0);
    chk("R3 request", s_req[14], 1);
    chk("R3 address", s_ra[14], rg);
    chk("R3 request one cycle", s_req[15], 0);
    chk("R4 first turnaround released", s_oe[14], 0);
    chk("R4 second turnaround drives 0", {s_oe[15], s_o[15]}, 2'b10);
    got = '0; oe_ok = 0;
    for (int i = 16; i < 32; i++) begin
      got = {got[14:0], s_o[i]};
      oe_ok += int'(s_oe[i]);
    end
    chk("R5 read data MSB first", got, rf_val(rg));
    chk("R5 drive held over data", oe_ok, 16);
    chk("R5 release after last bit", s_oe[32], 0);
  endtask

  task automatic t_mismatch();
    idle_ones(32);
    frame(2'b01, 2'b01, phy_strap ^ 5'h10, 5'h03, 16'h1234, 1'b0);
    expect_quiet("R6 write other address");
    idle_ones(32);
    frame(2'b01, 2'b10, phy_strap ^ 5'h01, 5'h03, 16'h0, 1'b1);
    expect_quiet("R6 read other address");
  endtask

  task automatic t_short_idle();
    idle_ones(31);
    frame(2'b01, 2'b01, phy_strap, 5'h07, 16'h0F0F, 1'b0);
    expect_quiet("R7 31 ones");
    t_write(5'h07, 16'h0F0F); // R7: 32 ones accepted
  endtask

  task automatic t_bad_start();
    idle_ones(32);
    frame(2'b00, 2'b01, phy_strap, 5'h02, 16'h5555, 1'b0);
    expect_quiet("R8 bad start");
  endtask

  task automatic t_bad_op();
    idle_ones(32);
    frame(2'b01, 2'b11, phy_strap, 5'h02, 16'h5555, 1'b0);
    expect_quiet("R9 opcode 11");
    idle_ones(32);
    frame(2'b01, 2'b00, phy_strap, 5'h02, 16'h5555, 1'b0);
    expect_quiet("R9 opcode 00");
  endtask

  task automatic t_no_fresh_idle();
    t_write(5'h11, 16'hBEEF);
    frame(2'b01, 2'b01, phy_strap, 5'h12, 16'h1357, 1'b0);
    expect_quiet("R10 no idle between frames");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write(5'h00, 16'hA5C3);
    t_write(5'h1F, 16'h8001);
    t_read(5'h01);
    t_read(5'h1E);
    t_mismatch();
    t_short_idle();
    t_bad_start();
    t_bad_op();
    t_no_fresh_idle();
    t_read(5'h15);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule